// File: doc/BRIEF.md
# Dual 16-bit Timer with 32-bit Join and Prescaler

The block holds two 16-bit up-counters, a lower and an upper timer, each with its own control word, count register and period register. All six registers sit on a small register bus. Each timer counts ticks from one of two sources. The first is an internal tick at half the system clock rate. The second is the rising edges of its own external pin, after the pin has been synchronized. A prescaler of 1, 8, 64 or 256 sits between the source and the counter. When the count reaches the period value, the next increment wraps the count to zero and raises a one-cycle interrupt.

A bit in the lower control word joins the two timers into one 32-bit counter. In that mode the lower control word governs everything, the upper control word is ignored, and interrupts appear only on the upper interrupt line. A read of the lower count half latches the upper half, so software obtains a coherent 32-bit value in two reads.

Each timer has two further options. In gated mode the internal tick counts only while the timer's gate input is high, and a falling edge on the gate raises the interrupt. With stop-in-idle set, counting pauses while the idle request is high.

Top module: `tmr_pair`

## Requirements
- R1: After reset, both control words and both counts read 0, both periods read 0xFFFF, and both interrupt lines are low.
- R2: Register addresses are: 0 lower control, 1 upper control, 2 lower count, 3 upper count, 4 lower period, 5 upper period. The lower control word keeps bits 15, 13, 6, 5, 4, 3 and 1, and the upper keeps 15, 13, 6, 5, 4 and 1. All other control bits ignore writes and read as 0.
- R3: Control bit 15 runs the timer. Control bit 1 = 0 selects the internal tick, which fires on every second system clock, so a run window of 2K clock edges adds K at 1:1. A stopped timer holds its count.
- R4: With control bit 1 = 1, each rising edge of the timer's pin adds exactly one count at 1:1, after the pin has been synchronized.
- R5: Control bits 5:4 select the prescale ratio: 00 is 1:1, 01 is 1:8, 10 is 1:64 and 11 is 1:256. The prescaler restarts on every write to that control word and while the timer is stopped.
- R6: An increment taken while the count equals the period sets the count to 0 and raises that timer's interrupt for exactly one cycle.
- R7: Control bit 6 with the internal source makes the timer count only while its gate input is high. A falling gate edge while the timer runs raises the interrupt, and a period match in this mode wraps the count without an interrupt. With the external source, bit 6 has no effect.
- R8: Control bit 13 stops counting while the idle request is high. With bit 13 clear, idle has no effect.
- R9: Lower control bit 3 joins the counts into one 32-bit counter, with the upper count as the high half, compared against the 32-bit period {upper, lower}. The counter is driven only by lower control bits, the upper control word is ignored, and the interrupt goes out on the upper line only.
- R10: In 32-bit mode, a read of the lower count copies the upper count into a holding register, and reads of the upper count return that copy.
- R11: Read data appears on the cycle after the read strobe and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| tmr_pin | input | 2 | External count pins, bit 0 lower timer |
| gate_in | input | 2 | Gate inputs for gated mode, bit 0 lower timer |
| idle_req | input | 1 | Idle request |
| irq | output | 2 | Interrupt pulses, bit 0 lower timer |

## Verification
A wrong count, prescaler phase or source selection shows up as a count value that is off when it is read after a run window of exactly known length. A window of 2K edges gives a fixed tick count regardless of the phase of the half-rate tick, so the error is visible on the first read after the window. A broken carry, a wrong period comparison or a stale holding register shows on the two-read 32-bit value and in the count of pulses on each interrupt line, within a few cycles of the edge that crosses the period. A wrong register mask appears on the first read-back of a control word.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int W     = 16;
    localparam int NT    = 2;
    localparam int AW    = 3;
    localparam int PS_W  = 8;

    // control word bit positions
    localparam int B_RUN  = 15;
    localparam int B_IDLE = 13;
    localparam int B_GATE = 6;
    localparam int B_PS   = 4;
    localparam int B_FUSE = 3;
    localparam int B_SRC  = 1;

    localparam logic [W-1:0] MASK_LO = 16'hA07A;
    localparam logic [W-1:0] MASK_HI = 16'hA072;

    localparam logic [AW-1:0] ADR_CTL_LO = 3'd0;
    localparam logic [AW-1:0] ADR_CTL_HI = 3'd1;
    localparam logic [AW-1:0] ADR_CNT_LO = 3'd2;
    localparam logic [AW-1:0] ADR_CNT_HI = 3'd3;
    localparam logic [AW-1:0] ADR_PER_LO = 3'd4;
    localparam logic [AW-1:0] ADR_PER_HI = 3'd5;

    typedef struct packed {
        logic [NT-1:0][W-1:0] ctl;
        logic [NT-1:0][W-1:0] cnt;
        logic [NT-1:0][W-1:0] per;
        logic [W-1:0]         hold;
        logic [W-1:0]         rdata;
        logic [NT-1:0]        irq;
        logic [NT-1:0]        pin_prev;
        logic [NT-1:0]        gate_prev;
        logic                 half;
    } tmr_st_t;

    // terminal value of the prescale counter for each ratio code
    function automatic logic [PS_W-1:0] ps_last(input logic [1:0] sel);
        case (sel)
            2'd0:    return PS_W'(0);
            2'd1:    return PS_W'(7);
            2'd2:    return PS_W'(63);
            default: return PS_W'(255);
        endcase
    endfunction

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl
);
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = din;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign lvl = sh_q[STAGES-1];
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       adv,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [PS_W-1:0] pc_q;
    logic [PS_W-1:0] pc_d;
    logic            at_end;

    always_comb begin
        at_end = (pc_q == ps_last(sel));
        tick   = adv && at_end;
        pc_d   = pc_q;
        if (clr)      pc_d = '0;
        else if (adv) pc_d = at_end ? '0 : pc_q + PS_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic [NT-1:0] tmr_pin,
    input  logic [NT-1:0] gate_in,
    input  logic          idle_req,
    output logic [NT-1:0] irq
);
    tmr_st_t s_q;
    tmr_st_t s_d;

    logic [NT-1:0] pin_lvl;
    logic [NT-1:0] gate_lvl;
    logic [NT-1:0] pin_rise;
    logic [NT-1:0] gate_fall;
    logic [NT-1:0] run;
    logic [NT-1:0] gated;
    logic [NT-1:0] src;
    logic [NT-1:0] adv;
    logic [NT-1:0] clr;
    logic [NT-1:0] ps_tick;
    logic          fuse;

    genvar g;
    generate
        for (g = 0; g < NT; g++) begin : g_tmr
            tmr_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
                .clk (clk),
                .rst_n (rst_n),
                .din (tmr_pin[g]),
                .lvl (pin_lvl[g])
            );
            tmr_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
                .clk (clk),
                .rst_n (rst_n),
                .din (gate_in[g]),
                .lvl (gate_lvl[g])
            );
            tmr_prescale u_ps (
                .clk  (clk),
                .rst_n (rst_n),
                .clr  (clr[g]),
                .adv  (adv[g]),
                .sel  (s_q.ctl[g][B_PS+1:B_PS]),
                .tick (ps_tick[g])
            );
        end
    endgenerate

    // per-timer qualifiers
    always_comb begin
        fuse = s_q.ctl[0][B_FUSE];
        for (int i = 0; i < NT; i++) begin
            pin_rise[i]  = pin_lvl[i] & ~s_q.pin_prev[i];
            gate_fall[i] = ~gate_lvl[i] & s_q.gate_prev[i];
            run[i]       = s_q.ctl[i][B_RUN];
            gated[i]     = !s_q.ctl[i][B_SRC] && s_q.ctl[i][B_GATE];
            src[i]       = s_q.ctl[i][B_SRC] ? pin_rise[i] : s_q.half;
            adv[i]       = run[i] && src[i]
                           && !(s_q.ctl[i][B_IDLE] && idle_req)
                           && (!gated[i] || gate_lvl[i])
                           && !(i == 1 && fuse);
            clr[i]       = !run[i] || (bus_wr && bus_addr == AW'(i));
        end
    end

    // next-state
    always_comb begin
        s_d           = s_q;
        s_d.half      = ~s_q.half;
        s_d.irq       = '0;
        s_d.pin_prev  = pin_lvl;
        s_d.gate_prev = gate_lvl;

        if (fuse) begin
            if (ps_tick[0]) begin
                if (s_q.cnt == s_q.per) begin
                    s_d.cnt    = '0;
                    s_d.irq[1] = !gated[0];
                end else begin
                    s_d.cnt = s_q.cnt + (NT*W)'(1);
                end
            end
            if (gated[0] && run[0] && gate_fall[0]) s_d.irq[1] = 1'b1;
        end else begin
            for (int i = 0; i < NT; i++) begin
                if (ps_tick[i]) begin
                    if (s_q.cnt[i] == s_q.per[i]) begin
                        s_d.cnt[i] = '0;
                        s_d.irq[i] = !gated[i];
                    end else begin
                        s_d.cnt[i] = s_q.cnt[i] + W'(1);
                    end
                end
                if (gated[i] && run[i] && gate_fall[i]) s_d.irq[i] = 1'b1;
            end
        end

        if (bus_wr) begin
            case (bus_addr)
                ADR_CTL_LO: s_d.ctl[0] = bus_wdata & MASK_LO;
                ADR_CTL_HI: s_d.ctl[1] = bus_wdata & MASK_HI;
                ADR_CNT_LO: s_d.cnt[0] = bus_wdata;
                ADR_CNT_HI: s_d.cnt[1] = bus_wdata;
                ADR_PER_LO: s_d.per[0] = bus_wdata;
                ADR_PER_HI: s_d.per[1] = bus_wdata;
                default: ;
            endcase
        end

        if (bus_rd) begin
            case (bus_addr)
                ADR_CTL_LO: s_d.rdata = s_q.ctl[0];
                ADR_CTL_HI: s_d.rdata = s_q.ctl[1];
                ADR_CNT_LO: begin
                    s_d.rdata = s_q.cnt[0];
                    if (fuse) s_d.hold = s_q.cnt[1];
                end
                ADR_CNT_HI: s_d.rdata = fuse ? s_q.hold : s_q.cnt[1];
                ADR_PER_LO: s_d.rdata = s_q.per[0];
                ADR_PER_HI: s_d.rdata = s_q.per[1];
                default:    s_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.per <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata = s_q.rdata;
    assign irq       = s_q.irq;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
    import tmr_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [W-1:0]  bus_rdata,
    input logic          idle_req,
    input logic [NT-1:0] irq,
    input logic          fuse,
    input tmr_st_t       s_q
);
    AST_CTL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADR_CTL_LO) |=> ((bus_rdata & ~MASK_LO) == '0)); // R2

    AST_IRQ_LO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq[0] |=> !irq[0]); // R6

    AST_IRQ_HI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq[1] |=> !irq[1]); // R6

    AST_JOINED_LO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fuse) |-> !irq[0]); // R9

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.ctl[0][B_RUN] && !bus_wr) |=> $stable(s_q.cnt[0])); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctl[0][B_IDLE] && idle_req && !bus_wr) |=> $stable(s_q.cnt[0])); // R8

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R11
endmodule

bind tmr_pair tmr_pair_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .idle_req  (idle_req),
    .irq       (irq),
    .fuse      (fuse),
    .s_q       (s_q)
);

// File: tb/tmr_pair_tb.sv
`timescale 1ns/1ps
module tmr_pair_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  tmr_pin = '0;
    logic [1:0]  gate_in = '0;
    logic        idle_req = 1'b0;
    logic [1:0]  irq;

    int          n_chk = 0;
    int          n_bad = 0;
    int          irq_n0 = 0;
    int          irq_n1 = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        rd_fl = 1'b0;
    logic [15:0] e_v;
    string       e_t;

    always #2.5 clk = ~clk;

    tmr_pair u_dut (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wr (bus_wr),
        .bus_rd (bus_rd), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .tmr_pin (tmr_pin), .gate_in (gate_in), .idle_req (idle_req), .irq (irq)
    );

    always @(posedge clk) rd_fl <= bus_rd;

    // monitor: interrupt tally and read-data scoreboard
    always @(negedge clk) begin
        if (irq[0]) irq_n0++;
        if (irq[1]) irq_n1++;
        if (rd_fl) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R11: read data %h with no expected item", bus_rdata);
            end else begin
                e_v = exp_q.pop_front();
                e_t = tag_q.pop_front();
                if (bus_rdata !== e_v) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", e_t, bus_rdata, e_v);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] ex, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(ex);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_n(input int act, input int ex, input string tag);
        n_chk++;
        if (act != ex) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, ex);
        end
    endtask

    // run window of exactly 'edges' clock edges with the run bit set
    task automatic win(input logic [15:0] on, input logic [15:0] off, input int edges);
        wr(3'd0, on);
        repeat (edges - 2) @(negedge clk);
        wr(3'd0, off);
    endtask

    task automatic pulse(input int idx, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tmr_pin[idx] = 1'b1;
            repeat (2) @(negedge clk);
            tmr_pin[idx] = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual still running expected finished");
        summary();
        $finish;
    end

    initial begin
        int b0;
        int b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_n(int'(irq), 0, "R1 irq after reset");
        rd(3'd0, 16'h0000, "R1 ctl lo");
        rd(3'd1, 16'h0000, "R1 ctl hi");
        rd(3'd2, 16'h0000, "R1 cnt lo");
        rd(3'd3, 16'h0000, "R1 cnt hi");
        rd(3'd4, 16'hFFFF, "R1 per lo");
        rd(3'd5, 16'hFFFF, "R1 per hi");

        // R2 control masks
        wr(3'd0, 16'hFFFF);
        rd(3'd0, 16'hA07A, "R2 ctl lo mask");
        wr(3'd1, 16'hFFFF);
        rd(3'd1, 16'hA072, "R2 ctl hi mask");
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h0000);

        // R3 internal tick, 20 edges -> 10
        win(16'h8000, 16'h0000, 20);
        rd(3'd2, 16'd10, "R3 internal count");
        repeat (10) @(negedge clk);
        rd(3'd2, 16'd10, "R3 stopped holds");

        // R5 internal 1:64, 256 edges -> 128 ticks -> 2
        wr(3'd2, 16'h0000);
        win(16'h8020, 16'h0020, 256);
        rd(3'd2, 16'd2, "R5 internal 1:64");

        // R4 external 1:1
        wr(3'd2, 16'h0000);
        wr(3'd0, 16'h8002);
        pulse(0, 5);
        settle();
        wr(3'd0, 16'h0002);
        rd(3'd2, 16'd5, "R4 external edges");

        // R5 external 1:8
        wr(3'd2, 16'h0000);
        wr(3'd0, 16'h8012);
        pulse(0, 16);
        settle();
        wr(3'd0, 16'h0012);
        rd(3'd2, 16'd2, "R5 external 1:8");

        // R6 period match
        wr(3'd4, 16'd3);
        wr(3'd2, 16'h0000);
        b0 = irq_n0;
        wr(3'd0, 16'h8002);
        pulse(0, 4);
        settle();
        rd(3'd2, 16'd0, "R6 wrap to zero");
        chk_n(irq_n0 - b0, 1, "R6 match pulse");
        pulse(0, 2);
        settle();
        rd(3'd2, 16'd2, "R6 counts after wrap");
        chk_n(irq_n0 - b0, 1, "R6 no extra pulse");
        wr(3'd0, 16'h0002);
        wr(3'd4, 16'hFFFF);

        // R7 gated accumulation
        wr(3'd2, 16'h0000);
        win(16'h8040, 16'h0040, 20);
        rd(3'd2, 16'd0, "R7 gate low blocks");
        gate_in[0] = 1'b1;
        settle();
        win(16'h8040, 16'h0040, 20);
        rd(3'd2, 16'd10, "R7 gate high counts");
        b0 = irq_n0;
        wr(3'd0, 16'h8040);
        gate_in[0] = 1'b0;
        settle();
        chk_n(irq_n0 - b0, 1, "R7 gate fall pulse");
        wr(3'd0, 16'h0040);
        wr(3'd2, 16'h0000);
        gate_in[0] = 1'b1;
        settle();
        b0 = irq_n0;
        wr(3'd0, 16'h8042);
        gate_in[0] = 1'b0;
        pulse(0, 3);
        settle();
        wr(3'd0, 16'h0042);
        rd(3'd2, 16'd3, "R7 gate ignored external");
        chk_n(irq_n0 - b0, 0, "R7 no gate pulse external");

        // R8 stop in idle
        wr(3'd2, 16'h0000);
        idle_req = 1'b1;
        win(16'hA000, 16'h2000, 20);
        rd(3'd2, 16'd0, "R8 idle stops");
        win(16'h8000, 16'h0000, 20);
        rd(3'd2, 16'd10, "R8 idle ignored when clear");
        idle_req = 1'b0;

        // R9 joined 32-bit counter, upper control ignored
        wr(3'd0, 16'h000A);
        wr(3'd1, 16'h8000);
        wr(3'd2, 16'hFFFE);
        wr(3'd3, 16'h0001);
        b0 = irq_n0; b1 = irq_n1;
        wr(3'd0, 16'h800A);
        pulse(0, 3);
        settle();
        wr(3'd0, 16'h000A);
        rd(3'd2, 16'h0001, "R9 joined low half");
        rd(3'd3, 16'h0002, "R9 joined carry");
        chk_n(irq_n0 - b0, 0, "R9 lower irq quiet");
        chk_n(irq_n1 - b1, 0, "R9 no match yet");

        // R10 coherent read via holding register
        wr(3'd3, 16'h5555);
        rd(3'd3, 16'h0002, "R10 upper from hold");
        rd(3'd2, 16'h0001, "R10 lower read");
        rd(3'd3, 16'h5555, "R10 hold refreshed");

        // R9 joined period match on upper line
        wr(3'd4, 16'd2);
        wr(3'd5, 16'd0);
        wr(3'd2, 16'h0000);
        wr(3'd3, 16'h0000);
        b0 = irq_n0; b1 = irq_n1;
        wr(3'd0, 16'h800A);
        pulse(0, 3);
        settle();
        wr(3'd0, 16'h000A);
        rd(3'd2, 16'h0000, "R9 joined wrap low");
        rd(3'd3, 16'h0000, "R9 joined wrap high");
        chk_n(irq_n1 - b1, 1, "R9 match on upper line");
        chk_n(irq_n0 - b0, 0, "R9 lower line silent");

        // upper timer alone in 16-bit mode
        wr(3'd0, 16'h0000);
        wr(3'd4, 16'hFFFF);
        wr(3'd5, 16'hFFFF);
        wr(3'd1, 16'h0002);
        wr(3'd2, 16'h0000);
        wr(3'd3, 16'h0000);
        wr(3'd1, 16'h8002);
        pulse(1, 4);
        settle();
        wr(3'd1, 16'h0002);
        rd(3'd3, 16'd4, "R4 upper external");
        rd(3'd2, 16'd0, "R9 lower untouched when split");

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule